// File: doc/BRIEF.md
# Replay FIFO with Mark and Rewind

A single-clock first-in first-out buffer for streams that sometimes have to be sent twice. Words enter through a write port gated by two active-low enables, and leave one per read request through a registered output. An active-low empty flag, an active-low full flag and two active-low threshold flags (almost empty, almost full) report the fill level.

A consumer that may need to replay part of the stream raises `mark_i`. On that edge the block remembers where the word now shown on `rd_data_o` came from. While `mark_i` stays high, pulling `rt_ni` low moves the read pointer back to that word, as often as needed. Until the mark is released, the writer is held off the remembered word so that it cannot be overwritten. Two asynchronous resets are provided. The master reset restores everything, including the threshold offsets, which it loads from parameters. The partial reset clears only the pointers, the mark and the output register.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_ni` is low, or after it is released with no other activity, `rd_data_o` is zero, `empty_no` is 0, `full_no` is 1, `almost_empty_no` is 0 and `almost_full_no` is 1.
- R2: Pulling `prst_ni` low empties the buffer, clears `rd_data_o` and ends mark mode, giving the same flag levels as R1. The threshold offsets stay in force.
- R3: A rising edge with `wr_en_ni`=0 and `wr_cs_ni`=0, when writes are allowed, stores `wr_data_i`. A rising edge with `rd_en_ni`=0, when `empty_no`=1, loads the oldest unread word into `rd_data_o`. Words come out in the order they were written.
- R4: A write while `full_no`=0, or with `wr_cs_ni`=1, is dropped. A read while `empty_no`=0 leaves `rd_data_o` unchanged.
- R5: `empty_no` is 0 exactly when no unread word exists, or in the cycle after a rewind. `full_no` is 0 exactly when the occupied span equals DEPTH. The span is counted from the read pointer, or from the mark while mark mode is active.
- R6: `almost_empty_no` is 0 when the unread count is at most AE_OFF. `almost_full_no` is 0 when the occupied span is at least DEPTH-AF_OFF.
- R7: A rising edge with `mark_i`=1 while mark mode is inactive enters mark mode, provided the conditions of R11 hold. The mark records the location of the word currently in `rd_data_o`. Holding `mark_i` high does not move the mark.
- R8: In mark mode the write pointer never advances more than DEPTH locations past the mark. Writes that would do so are dropped and `full_no` reads 0.
- R9: A rising edge with `rt_ni`=0 and `mark_i`=1 in mark mode rewinds the read pointer to the mark. It blocks any read on that edge and the next one, and drives `empty_no` to 0 for one cycle. The next accepted read returns the marked word. A rewind can be repeated any number of times.
- R10: A rising edge with `mark_i`=0 ends mark mode. A rewind request outside mark mode is ignored.
- R11: A mark request is ignored unless a word has been read since the last reset, and the span from the marked word to the write pointer is at most DEPTH-MIN_SEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, asynchronous, active low |
| wr_data_i | input | DATA_W | Write data |
| wr_en_ni | input | 1 | Write enable, active low |
| wr_cs_ni | input | 1 | Write select, active low |
| rd_en_ni | input | 1 | Read enable, active low |
| mark_i | input | 1 | Mark request / hold mark mode |
| rt_ni | input | 1 | Rewind request, active low |
| rd_data_o | output | DATA_W | Registered read data |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| almost_empty_no | output | 1 | Almost-empty flag, active low |
| almost_full_no | output | 1 | Almost-full flag, active low |

## Verification
A wrong pointer shows at the ports in the cycle after it goes wrong. Either a flag moves at the wrong fill level, or `rd_data_o` carries a word out of order on the next accepted read. A stale or misplaced mark stays hidden until a rewind, and then the first read after the one-cycle empty pulse returns the wrong word. A failure to hold the writer back shows only once the span reaches DEPTH: `full_no` stays high, and the overwritten word comes back on the next rewind. The stimulus therefore mixes long fills under a held mark with repeated rewinds and partial resets.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic aempty_n;
    logic afull_n;
  } flags_t;
endpackage

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(i)) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl #(
  parameter int DEPTH   = 32,
  parameter int MIN_SEP = 8,
  parameter int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          mark_i,
  input  logic          rt_req_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] mark_ptr_o,
  output logic [PW-1:0] count_o,
  output logic [PW-1:0] occ_o,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          rt_go_o,
  output logic          mark_act_o,
  output logic          rt_busy_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] SEP_LIM = PW'(DEPTH - MIN_SEP);

  logic [PW-1:0] wptr_q, rptr_q, mark_q;
  logic          mark_act_q, rt_busy_q, out_vld_q;
  logic [PW-1:0] count, base, occ, sep;
  logic          rt_go, rd_ok, wr_ok, mark_go;

  assign count = wptr_q - rptr_q;
  assign base  = mark_act_q ? mark_q : rptr_q;
  assign occ   = wptr_q - base;
  // span from the word in the output register up to the write pointer
  assign sep   = count + PW'(1);

  assign rt_go   = rt_req_i & mark_act_q & mark_i;
  assign rd_ok   = rd_req_i & (count != '0) & ~rt_busy_q & ~rt_go;
  assign wr_ok   = wr_req_i & (occ != DEPTH_P);
  assign mark_go = mark_i & ~mark_act_q & out_vld_q & (sep <= SEP_LIM);

  always_ff @(posedge clk_i or negedge rst_ni or negedge prst_ni) begin
    if (!rst_ni || !prst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      mark_q     <= '0;
      mark_act_q <= 1'b0;
      rt_busy_q  <= 1'b0;
      out_vld_q  <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + PW'(1);
      if (rt_go)      rptr_q <= mark_q;
      else if (rd_ok) rptr_q <= rptr_q + PW'(1);
      if (rd_ok) out_vld_q <= 1'b1;
      rt_busy_q <= rt_go;
      if (!mark_i)      mark_act_q <= 1'b0;
      else if (mark_go) mark_act_q <= 1'b1;
      if (mark_go) mark_q <= rptr_q - PW'(1);
    end
  end

  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign mark_ptr_o = mark_q;
  assign count_o    = count;
  assign occ_o      = occ;
  assign wr_ok_o    = wr_ok;
  assign rd_ok_o    = rd_ok;
  assign rt_go_o    = rt_go;
  assign mark_act_o = mark_act_q;
  assign rt_busy_o  = rt_busy_q;
endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AE_OFF = 4,
  parameter int AF_OFF = 4,
  parameter int PW     = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] count_i,
  input  logic [PW-1:0] occ_i,
  input  logic          rt_busy_i,
  output flags_t        flags_o
);
  logic [PW-1:0] ae_lim_q, af_lim_q;

  // offsets: loaded by master reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_lim_q <= PW'(AE_OFF);
      af_lim_q <= PW'(DEPTH - AF_OFF);
    end
  end

  always_comb begin
    flags_o.empty_n  = (count_i != '0) & ~rt_busy_i;
    flags_o.full_n   = (occ_i != PW'(DEPTH));
    flags_o.aempty_n = (count_i > ae_lim_q);
    flags_o.afull_n  = (occ_i < af_lim_q);
  end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int DATA_W  = 20,
  parameter int DEPTH   = 32,
  parameter int AE_OFF  = 4,
  parameter int AF_OFF  = 4,
  parameter int MIN_SEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_ni,
  input  logic              wr_cs_ni,
  input  logic              rd_en_ni,
  input  logic              mark_i,
  input  logic              rt_ni,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_no,
  output logic              full_no,
  output logic              almost_empty_no,
  output logic              almost_full_no
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wptr, rptr, mark_ptr, count, occ;
  logic              wr_ok, rd_ok, rt_go, mark_act, rt_busy;
  logic [DATA_W-1:0] rdata_mem, rd_q;
  flags_t            flags;

  replay_fifo_ctrl #(.DEPTH(DEPTH), .MIN_SEP(MIN_SEP), .PW(PW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prst_ni    (prst_ni),
    .wr_req_i   (~wr_en_ni & ~wr_cs_ni),
    .rd_req_i   (~rd_en_ni),
    .mark_i     (mark_i),
    .rt_req_i   (~rt_ni),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .mark_ptr_o (mark_ptr),
    .count_o    (count),
    .occ_o      (occ),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .rt_go_o    (rt_go),
    .mark_act_o (mark_act),
    .rt_busy_o  (rt_busy)
  );

  replay_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (rdata_mem)
  );

  replay_fifo_flags #(.DEPTH(DEPTH), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF), .PW(PW)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .occ_i     (occ),
    .rt_busy_i (rt_busy),
    .flags_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni or negedge prst_ni) begin
    if (!rst_ni || !prst_ni) rd_q <= '0;
    else if (rd_ok)          rd_q <= rdata_mem;
  end

  assign rd_data_o       = rd_q;
  assign empty_no        = flags.empty_n;
  assign full_no         = flags.full_n;
  assign almost_empty_no = flags.aempty_n;
  assign almost_full_no  = flags.afull_n;
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 32,
  parameter int PW     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prst_ni,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              empty_no,
  input logic              full_no,
  input logic              almost_full_no,
  input logic              rt_go,
  input logic              rt_busy,
  input logic              mark_act,
  input logic [PW-1:0]     wptr,
  input logic [PW-1:0]     rptr,
  input logic [PW-1:0]     mark_ptr
);
  logic              live_q, prev_empty_n_q, prev_rt_go_q, prev_busy_q;
  logic [DATA_W-1:0] prev_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni or negedge prst_ni) begin
    if (!rst_ni || !prst_ni) begin
      live_q         <= 1'b0;
      prev_empty_n_q <= 1'b1;
      prev_rt_go_q   <= 1'b0;
      prev_busy_q    <= 1'b0;
      prev_rd_q      <= '0;
    end else begin
      live_q         <= 1'b1;
      prev_empty_n_q <= empty_no;
      prev_rt_go_q   <= rt_go;
      prev_busy_q    <= rt_busy;
      prev_rd_q      <= rd_data_o;
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    live_q && !prev_empty_n_q |-> rd_data_o == prev_rd_q);
  // R9
  rt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    live_q && prev_rt_go_q |-> !empty_no);
  // R9
  rt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    live_q && prev_busy_q && !prev_rt_go_q |-> !rt_busy);
  // R8
  mark_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    mark_act |-> (wptr - mark_ptr) <= PW'(DEPTH));
  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    (wptr - rptr) <= PW'(DEPTH));
  // R5
  empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    (wptr == rptr) |-> !empty_no);
  // R6
  af_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !prst_ni)
    !full_no |-> !almost_full_no);
endmodule

bind replay_fifo replay_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .prst_ni        (prst_ni),
  .rd_data_o      (rd_data_o),
  .empty_no       (empty_no),
  .full_no        (full_no),
  .almost_full_no (almost_full_no),
  .rt_go          (rt_go),
  .rt_busy        (rt_busy),
  .mark_act       (mark_act),
  .wptr           (wptr),
  .rptr           (rptr),
  .mark_ptr       (mark_ptr)
);

// File: tb/tb_replay_fifo.sv
`timescale 1ns/1ps
module tb_replay_fifo;
  localparam int DW = 20, DEPTH = 32, AE = 4, AF = 4, MSEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic we_n = 1'b1, cs_n = 1'b0, re_n = 1'b1, mk = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] dout;
  logic empty_n, full_n, aempty_n, afull_n;

  int checks = 0, fails = 0;

  // reference state
  logic [DW-1:0] m_mem [DEPTH];
  int m_wp, m_rp, m_mk;
  bit m_mact, m_ovld, m_rtb;
  logic [DW-1:0] m_dout;

  always #2 clk = ~clk;

  replay_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF), .MIN_SEP(MSEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .prst_ni(prst_n), .wr_data_i(din),
    .wr_en_ni(we_n), .wr_cs_ni(cs_n), .rd_en_ni(re_n), .mark_i(mk), .rt_ni(rt_n),
    .rd_data_o(dout), .empty_no(empty_n), .full_no(full_n),
    .almost_empty_no(aempty_n), .almost_full_no(afull_n)
  );

  function automatic int m_count(); return m_wp - m_rp; endfunction
  function automatic int m_occ(); return m_wp - (m_mact ? m_mk : m_rp); endfunction

  task automatic m_reset();
    m_wp = 0; m_rp = 0; m_mk = 0; m_mact = 0; m_ovld = 0; m_rtb = 0; m_dout = '0;
  endtask

  task automatic m_update();
    int cnt, occ;
    bit rt_go, rd_ok, wr_ok, mark_go;
    cnt = m_count(); occ = m_occ();
    rt_go   = !rt_n && m_mact && mk;
    rd_ok   = !re_n && cnt > 0 && !m_rtb && !rt_go;
    wr_ok   = !we_n && !cs_n && occ < DEPTH;
    mark_go = mk && !m_mact && m_ovld && (cnt + 1) <= DEPTH - MSEP;
    if (rd_ok) begin m_dout = m_mem[m_rp % DEPTH]; m_ovld = 1; end
    if (wr_ok) begin m_mem[m_wp % DEPTH] = din; m_wp++; end
    if (mark_go) m_mk = m_rp - 1;
    if (rt_go) m_rp = m_mk; else if (rd_ok) m_rp++;
    m_rtb = rt_go;
    if (!mk) m_mact = 0; else if (mark_go) m_mact = 1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "rd_data_o", int'(dout), int'(m_dout));
    check(tag, "empty_no", int'(empty_n), int'(!(m_count() == 0 || m_rtb)));
    check(tag, "full_no", int'(full_n), int'(m_occ() != DEPTH));
    check(tag, "almost_empty_no", int'(aempty_n), int'(m_count() > AE));
    check(tag, "almost_full_no", int'(afull_n), int'(m_occ() < DEPTH - AF));
  endtask

  task automatic cyc(input string tag);
    @(posedge clk); m_update();
    @(negedge clk); check_all(tag);
  endtask

  task automatic idle();
    we_n = 1; re_n = 1; rt_n = 1;
  endtask

  task automatic do_prst(input string tag);
    prst_n = 0; #1;
    m_reset(); check_all(tag);
    #0.5 prst_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    cyc("R1");

    // five words
    for (int i = 0; i < 5; i++) begin we_n = 0; din = DW'(100 + i); cyc("R3"); end
    idle();
    // mark before any read: rejected, rewind ignored
    mk = 1; cyc("R11");
    rt_n = 0; cyc("R11");
    rt_n = 1; mk = 0; cyc("R10");
    // two reads
    re_n = 0; cyc("R3"); cyc("R3");
    re_n = 1; mk = 1; cyc("R7");
    // drain while mark held, then read on empty
    re_n = 0; cyc("R3"); cyc("R3"); cyc("R3");
    cyc("R4"); cyc("R4");
    re_n = 1;
    // rewind, twice
    for (int k = 0; k < 2; k++) begin
      rt_n = 0; cyc("R9");
      rt_n = 1; re_n = 0; cyc("R9");
      cyc("R9"); cyc("R9");
      re_n = 1;
    end
    // fill under mark until blocked
    for (int i = 0; i < 40; i++) begin we_n = 0; din = DW'(200 + i); cyc("R8"); end
    idle(); cyc("R8");
    rt_n = 0; cyc("R9"); rt_n = 1; re_n = 0; cyc("R9"); cyc("R9"); re_n = 1;
    mk = 0; cyc("R10");
    rt_n = 0; cyc("R10"); rt_n = 1;
    // partial reset
    do_prst("R2");
    cyc("R2");
    // separation limit
    for (int i = 0; i < 30; i++) begin we_n = 0; din = DW'(300 + i); cyc("R6"); end
    we_n = 1; re_n = 0; cyc("R3"); re_n = 1;
    mk = 1; cyc("R11");
    mk = 0; cyc("R11");
    // full, then write on full and with select high
    for (int i = 0; i < 6; i++) begin we_n = 0; din = DW'(400 + i); cyc("R4"); end
    cs_n = 1; re_n = 0; cyc("R4");
    cs_n = 0; re_n = 1; we_n = 0; din = DW'(999); cyc("R4");
    idle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      we_n = ($urandom % 100) < 50 ? 1'b0 : 1'b1;
      re_n = ($urandom % 100) < 48 ? 1'b0 : 1'b1;
      cs_n = ($urandom % 12) == 0;
      rt_n = ($urandom % 16) == 0 ? 1'b0 : 1'b1;
      if (($urandom % 40) == 0) mk = ~mk;
      din = DW'($urandom);
      if (($urandom % 500) == 0) begin
        idle(); do_prst("R2");
      end
      cyc("R3");
    end
    idle(); mk = 0;
    cyc("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule